// File: doc/BRIEF.md
# Indirect Codec Register Bridge

This block lets a processor on a 32-bit memory-mapped bus reach a small file of 8-bit codec control registers through two bus words. A command word holds a write-request flag, a 7-bit register index and a data byte. A status word returns the byte at the selected index, along with a pending-interrupt indication. Software starts an internal write by setting the request flag. It then polls the flag until the block clears it. To read, software writes a new index with the flag clear and reads the status word once the fixed read latency has passed.

The register file keeps 28 bytes. Each byte has its own value after reset. Two indices are reserved for factory test and cannot be reached from the bus. A write command that arrives while an earlier write is still in progress is dropped without effect.

Top module: `codec_regbridge`

## Requirements
- R1: After reset the command word reads 0x00000000, and the 28 registers hold these values for indices 0 up to 27: 0c aa 78 00 00 ff 03 51 3f 00 00 04 04 04 04 04 04 0a 0a 00 00 00 c0 34 07 44 1f 00 (hex).
- R2: The command word is at bus offset 0x0. Its bit 16 is the write-busy flag, bits 14:8 are the current index and bits 7:0 are the last accepted write byte; all other bits read 0. The status word is at offset 0x4. Its bits 7:0 hold the selected register byte and bit 8 is the interrupt flag; all other bits read 0. Any other offset reads 0.
- R3: A bus write to offset 0x0 with bit 16 set, accepted while idle, makes bit 16 read 1 for exactly 4 cycles, starting in the cycle after the write. Once bit 16 is 0 again, the register at the index given by bits 14:8 holds the byte given by bits 7:0.
- R4: A bus write to offset 0x0 while bit 16 reads 1 is ignored. The index field, the data field and every register stay unchanged.
- R5: A bus write to offset 0x0 with bit 16 clear, accepted while idle, changes only the index field. The data field and the registers keep their values, and no busy period starts.
- R6: The status word's bits 7:0 show the selected register's byte no later than 6 cycles after the index is updated, or after a write to that register completes.
- R7: Indices 20 and 21, and every index from 28 to 127, read as 0x00. Writes to them change no register, but the busy period still runs its full length.
- R8: Bit 8 of the status word is 1 exactly when some bit of register 9 is 1.
- R9: Bus writes to any offset other than 0x0 leave the command word's index and data fields and all registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Bus write strobe, one cycle per write |
| bus_addr | input | 4 | Byte offset of the accessed word |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
The busy flag goes high in the cycle after an accepted write command and stays high for four cycles. The bench therefore samples bit 16 at the falling edge after each of the next four rising edges and expects 1 each time, then expects 0 at the fifth. The status byte is due at most six cycles after an index update. Every read check sets the index first and samples at the sixth falling edge after the accepting rising edge. That sample comes after every pipeline register on the read path has been loaded. The interrupt bit follows register 9 without delay, so it is checked once the busy flag has dropped.

// File: rtl/codec_rb_pkg.sv
package codec_rb_pkg;

    localparam int unsigned REG_COUNT   = 28;
    localparam int unsigned IDX_W       = 7;
    localparam int unsigned BYTE_W      = 8;
    localparam int unsigned TEST_IDX_A  = 20;
    localparam int unsigned TEST_IDX_B  = 21;
    localparam int unsigned IRQ_IDX     = 9;

    // command word field positions (software decodes these)
    localparam int unsigned GO_BIT      = 16;
    localparam int unsigned IDX_LSB     = 8;
    localparam int unsigned IRQ_BIT     = 8;

    typedef struct packed {
        logic              go;
        logic [IDX_W-1:0]  idx;
        logic [BYTE_W-1:0] data;
    } cmd_t;

    function automatic logic [7:0] reset_byte(input int unsigned idx);
        logic [7:0] v;
        case (idx)
            0:       v = 8'h0c;
            1:       v = 8'haa;
            2:       v = 8'h78;
            5:       v = 8'hff;
            6:       v = 8'h03;
            7:       v = 8'h51;
            8:       v = 8'h3f;
            11, 12, 13, 14, 15, 16: v = 8'h04;
            17, 18:  v = 8'h0a;
            22:      v = 8'hc0;
            23:      v = 8'h34;
            24:      v = 8'h07;
            25:      v = 8'h44;
            26:      v = 8'h1f;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/codec_wr_seq.sv
module codec_wr_seq
    import codec_rb_pkg::*;
#(
    parameter int unsigned WR_CYCLES = 4,
    parameter int unsigned AW        = IDX_W,
    parameter int unsigned DW        = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_we,
    input  logic          cmd_go,
    input  logic [AW-1:0] cmd_idx,
    input  logic [DW-1:0] cmd_data,
    output logic          busy_o,
    output logic [AW-1:0] idx_o,
    output logic [DW-1:0] data_o,
    output logic          commit_o
);

    localparam int unsigned CW = $clog2(WR_CYCLES + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic [AW-1:0] idx;
        logic [DW-1:0] data;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        commit_o = 1'b0;
        if (s_q.busy) begin
            if (s_q.cnt == '0) begin
                s_d.busy = 1'b0;
                commit_o = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end else if (cmd_we) begin
            s_d.idx = cmd_idx;
            if (cmd_go) begin
                s_d.data = cmd_data;
                s_d.busy = 1'b1;
                s_d.cnt  = CW'(WR_CYCLES - 1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy_o = s_q.busy;
    assign idx_o  = s_q.idx;
    assign data_o = s_q.data;

    a_r4_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && cmd_we) |=> ($stable(s_q.idx) && $stable(s_q.data)));

    a_r3_commit_clears: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> !s_q.busy);

    a_r3_busy_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.busy && cmd_we && cmd_go) |=> (s_q.busy && s_q.cnt == CW'(WR_CYCLES - 1)));

    a_r5_no_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.busy && cmd_we && !cmd_go) |=> (!s_q.busy && $stable(s_q.data)));

endmodule

// File: rtl/codec_regfile.sv
module codec_regfile
    import codec_rb_pkg::*;
#(
    parameter int unsigned NREG = REG_COUNT,
    parameter int unsigned AW   = IDX_W,
    parameter int unsigned DW   = BYTE_W,
    parameter int unsigned BLK_A = TEST_IDX_A,
    parameter int unsigned BLK_B = TEST_IDX_B,
    parameter int unsigned FLAG_IDX = IRQ_IDX
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_idx,
    output logic [DW-1:0] rd_data,
    output logic          irq_o
);

    logic [NREG-1:0][DW-1:0] regs_d, regs_q;
    logic [NREG-1:0]         open_map;

    for (genvar g = 0; g < NREG; g++) begin : g_open
        assign open_map[g] = (g != BLK_A) && (g != BLK_B);
    end

    always_comb begin
        regs_d = regs_q;
        for (int i = 0; i < NREG; i++) begin
            if (wr_en && open_map[i] && wr_idx == AW'(i)) regs_d[i] = wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++) begin
            if (open_map[i] && rd_idx == AW'(i)) rd_data = regs_q[i];
        end
    end

    assign irq_o = |regs_q[FLAG_IDX];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= DW'(reset_byte(i));
        end else begin
            regs_q <= regs_d;
        end
    end

    a_r7_blocked_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_idx == AW'(BLK_A) || wr_idx == AW'(BLK_B) || wr_idx >= AW'(NREG)))
        |=> $stable(regs_q));

    a_r7_blocked_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx == AW'(BLK_A) || rd_idx == AW'(BLK_B) || rd_idx >= AW'(NREG))
        |-> rd_data == '0);

    a_r4_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_q));

endmodule

// File: rtl/codec_rd_pipe.sv
module codec_rd_pipe #(
    parameter int unsigned STAGES = 3,
    parameter int unsigned W      = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] in_d,
    output logic [W-1:0] out_q
);

    if (STAGES == 0) begin : g_bypass
        assign out_q = in_d;
    end else begin : g_stages
        logic [W-1:0] st_d [STAGES];
        logic [W-1:0] st_q [STAGES];

        always_comb begin
            st_d[0] = in_d;
            for (int i = 1; i < STAGES; i++) st_d[i] = st_q[i-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < STAGES; i++) st_q[i] <= '0;
            end else begin
                for (int i = 0; i < STAGES; i++) st_q[i] <= st_d[i];
            end
        end

        assign out_q = st_q[STAGES-1];

        a_r6_first_stage: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> st_q[0] == $past(in_d));
    end

endmodule

// File: rtl/codec_regbridge.sv
module codec_regbridge
    import codec_rb_pkg::*;
#(
    parameter int unsigned WR_CYCLES = 4,
    parameter int unsigned RD_STAGES = 3,
    parameter int unsigned BUS_AW    = 4,
    parameter int unsigned CMD_OFS   = 0,
    parameter int unsigned DAT_OFS   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);

    cmd_t                cmd_in;
    logic                cmd_we;
    logic                busy;
    logic                commit;
    logic                irq;
    logic [IDX_W-1:0]    cur_idx;
    logic [BYTE_W-1:0]   cur_data;
    logic [BYTE_W-1:0]   rd_byte;
    logic [BYTE_W-1:0]   rd_byte_q;
    logic                unused_wdata;

    assign cmd_in.go   = bus_wdata[GO_BIT];
    assign cmd_in.idx  = bus_wdata[IDX_LSB +: IDX_W];
    assign cmd_in.data = bus_wdata[BYTE_W-1:0];
    assign cmd_we      = bus_we && (bus_addr == BUS_AW'(CMD_OFS));
    assign unused_wdata = ^{bus_wdata[31:GO_BIT+1], bus_wdata[IDX_LSB+IDX_W]};

    codec_wr_seq #(
        .WR_CYCLES (WR_CYCLES),
        .AW        (IDX_W),
        .DW        (BYTE_W)
    ) u_wseq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_we   (cmd_we),
        .cmd_go   (cmd_in.go),
        .cmd_idx  (cmd_in.idx),
        .cmd_data (cmd_in.data),
        .busy_o   (busy),
        .idx_o    (cur_idx),
        .data_o   (cur_data),
        .commit_o (commit)
    );

    codec_regfile #(
        .NREG     (REG_COUNT),
        .AW       (IDX_W),
        .DW       (BYTE_W),
        .BLK_A    (TEST_IDX_A),
        .BLK_B    (TEST_IDX_B),
        .FLAG_IDX (IRQ_IDX)
    ) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (commit),
        .wr_idx  (cur_idx),
        .wr_data (cur_data),
        .rd_idx  (cur_idx),
        .rd_data (rd_byte),
        .irq_o   (irq)
    );

    codec_rd_pipe #(
        .STAGES (RD_STAGES),
        .W      (BYTE_W)
    ) u_rpipe (
        .clk   (clk),
        .rst_n (rst_n),
        .in_d  (rd_byte),
        .out_q (rd_byte_q)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == BUS_AW'(CMD_OFS)) begin
            bus_rdata[GO_BIT]                = busy;
            bus_rdata[IDX_LSB +: IDX_W]      = cur_idx;
            bus_rdata[BYTE_W-1:0]            = cur_data;
        end else if (bus_addr == BUS_AW'(DAT_OFS)) begin
            bus_rdata[IRQ_BIT]               = irq;
            bus_rdata[BYTE_W-1:0]            = rd_byte_q;
        end
    end

    a_r9_other_ofs: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr != BUS_AW'(CMD_OFS)) |=> ($stable(cur_idx) && $stable(cur_data)));

    a_r3_write_only_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> busy);

endmodule

// File: tb/codec_regbridge_tb.sv
module codec_regbridge_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    bit          finished = 1'b0;
    logic [7:0]  exp_reg [28];
    logic [6:0]  exp_idx = '0;
    logic [7:0]  exp_dat = '0;

    always #10 clk = ~clk;

    codec_regbridge u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    function automatic logic [7:0] dflt(input int i);
        logic [7:0] t [28] = '{8'h0c,8'haa,8'h78,8'h00,8'h00,8'hff,8'h03,8'h51,
                                8'h3f,8'h00,8'h00,8'h04,8'h04,8'h04,8'h04,8'h04,
                                8'h04,8'h0a,8'h0a,8'h00,8'h00,8'h00,8'hc0,8'h34,
                                8'h07,8'h44,8'h1f,8'h00};
        return t[i];
    endfunction

    function automatic bit reachable(input int i);
        return (i < 28) && (i != 20) && (i != 21);
    endfunction

    function automatic logic [7:0] expect_read(input int i);
        return reachable(i) ? exp_reg[i] : 8'h00;
    endfunction

    function automatic logic [31:0] cmd_word(input bit busy, input logic [6:0] i, input logic [7:0] d);
        return {15'h0, busy, 1'b0, i, d};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic peek(input logic [3:0] ofs, output logic [31:0] v);
        bus_addr = ofs;
        #1 v = bus_rdata;
    endtask

    task automatic put(input logic [3:0] ofs, input logic [31:0] w);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = ofs; bus_wdata = w;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    // R3: write with busy-length and result checks
    task automatic do_write(input logic [6:0] i, input logic [7:0] d);
        logic [31:0] v;
        bit ok = 1'b1;
        put(4'h0, {15'h0, 1'b1, 1'b0, i, d});
        for (int k = 0; k < 4; k++) begin
            peek(4'h0, v);
            if (v[16] !== 1'b1) ok = 1'b0;
            @(negedge clk);
        end
        peek(4'h0, v);
        if (v[16] !== 1'b0) ok = 1'b0;
        check("R3 busy lasts 4 cycles", {31'h0, ok}, 32'h1);
        exp_idx = i; exp_dat = d;
        if (reachable(int'(i))) exp_reg[i] = d;
        check("R2 command word after write", v, cmd_word(1'b0, exp_idx, exp_dat));
    endtask

    // R5/R6: index update then read after 6 cycles
    task automatic read_idx(input logic [6:0] i, input string tag);
        logic [31:0] v;
        put(4'h0, {15'h0, 1'b0, 1'b0, i, 8'h5c});
        exp_idx = i;
        peek(4'h0, v);
        check("R5 index-only update", v, cmd_word(1'b0, exp_idx, exp_dat));
        repeat (5) @(negedge clk);
        peek(4'h4, v);
        check(tag, v, {23'h0, |exp_reg[9], expect_read(int'(i))});
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 28; i++) exp_reg[i] = dflt(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        peek(4'h0, v);
        check("R1 command word at reset", v, 32'h0);

        // R1 defaults, read through R6 path
        for (int i = 0; i < 28; i++) read_idx(7'(i), "R1 reset default");

        // R7 blocked and out-of-range
        do_write(7'd20, 8'h5a);
        read_idx(7'd20, "R7 test index reads zero");
        do_write(7'd21, 8'hc3);
        read_idx(7'd21, "R7 test index reads zero");
        do_write(7'd100, 8'h33);
        read_idx(7'd100, "R7 out of range reads zero");
        read_idx(7'd19, "R7 neighbour unchanged");
        read_idx(7'd22, "R7 neighbour unchanged");

        // R4 write while busy ignored
        put(4'h0, {15'h0, 1'b1, 1'b0, 7'd2, 8'h11});
        put(4'h0, {15'h0, 1'b1, 1'b0, 7'd3, 8'h22});
        repeat (4) @(negedge clk);
        exp_idx = 7'd2; exp_dat = 8'h11; exp_reg[2] = 8'h11;
        peek(4'h0, v);
        check("R4 busy write dropped", v, cmd_word(1'b0, exp_idx, exp_dat));
        read_idx(7'd3, "R4 target of dropped write unchanged");
        read_idx(7'd2, "R4 first write landed");

        // R9 other offsets
        put(4'h4, {15'h0, 1'b1, 1'b0, 7'd5, 8'h66});
        put(4'h8, {15'h0, 1'b1, 1'b0, 7'd6, 8'h77});
        peek(4'h0, v);
        check("R9 other offset write ignored", v, cmd_word(1'b0, exp_idx, exp_dat));
        peek(4'h8, v);
        check("R2 unmapped offset reads zero", v, 32'h0);
        read_idx(7'd5, "R9 register unchanged");
        read_idx(7'd6, "R9 register unchanged");

        // R8 interrupt bit
        do_write(7'd9, 8'h08);
        peek(4'h4, v);
        check("R8 irq set", {31'h0, v[8]}, 32'h1);
        do_write(7'd9, 8'h00);
        peek(4'h4, v);
        check("R8 irq clear", {31'h0, v[8]}, 32'h0);

        // random mix
        for (int n = 0; n < 60; n++) begin
            int unsigned r = $urandom;
            logic [6:0] i = (r[3:0] == 4'h0) ? 7'($urandom % 128) : 7'($urandom % 28);
            logic [7:0] d = 8'($urandom);
            do_write(i, d);
            read_idx(7'($urandom % 32), "R6 random readback");
            read_idx(i, "R3 random write result");
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule